// File: doc/BRIEF.md
# Three-Channel Pixel Port Demultiplexer

This block takes one pixel per clock, made of three 8-bit colour samples (red, green, blue) and one out-of-range flag per sample, and places it on the outputs one clock after capture. In single-port mode every pixel goes to port A at the full pixel rate. In dual-port mode pixels alternate between port A and port B, so each port runs at half the pixel rate. A select input decides which port carries the odd pixels. A second select decides whether the two ports update together or one clock apart.

The odd/even phase is restarted by the horizontal sync input. The first pixel captured after sync is released counts as odd. In dual-port mode a half-rate marker output flags the cycles in which freshly paired data sits on both ports. An optional blanking mode forces all sample data and flags to zero while sync or clamp is active. An active-high output-disable puts every output into high impedance. All configuration inputs are static register bits, held constant by the surrounding logic.

Top module: `rgb_port_demux`

## Requirements
- R1: Each pixel is a bundle of three 8-bit straight-binary samples and three out-of-range flags (bit 0 red, bit 1 green, bit 2 blue); all of them travel together to the same port in the same cycle.
- R2: With `cfg_two_port` = 0, port A shows on the cycle after each rising edge the pixel captured at that edge.
- R3: With `cfg_two_port` = 0, every port B data and flag output is 0.
- R4: The phase restarts at odd while `hsync` is 1. The first pixel captured with `hsync` = 0 is odd, and the parity then alternates every clock. In dual-port mode odd and even pixels go to different ports.
- R5: With `cfg_odd_on_a` = 1, odd pixels go to port A and even pixels to port B; with 0, the assignment is swapped.
- R6: Dual-port with `cfg_stagger` = 0 (synchronous): both ports update only at the edge that captures an even pixel. The even pixel appears 1 cycle after capture and the preceding odd pixel 2 cycles after its capture.
- R7: Dual-port with `cfg_stagger` = 1 (interleaved): the odd port updates 1 cycle after an odd capture and the even port 1 cycle after an even capture, so the ports change on alternate clocks.
- R8: With `cfg_blank_en` = 1, all data and out-of-range outputs of both ports are 0 in any cycle where `hsync` or `clamp` is 1. The effect is immediate, with no added latency.
- R9: With `oe_n` = 1, every output is high impedance; with 0 they are driven.
- R10: `half_clk` is 1 in the cycle after an even pixel is captured in dual-port mode, and 0 otherwise and always in single-port mode.
- R11: While `rst_n` is 0 at a rising edge, all port registers and `half_clk` clear to 0 and the phase returns to odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_red | input | 8 | Red sample |
| in_grn | input | 8 | Green sample |
| in_blu | input | 8 | Blue sample |
| in_oor | input | 3 | Out-of-range flags {blue, green, red} |
| cfg_two_port | input | 1 | 0 single port A, 1 split over A and B |
| cfg_odd_on_a | input | 1 | 1 odd pixels on port A |
| cfg_stagger | input | 1 | 0 synchronous ports, 1 interleaved ports |
| cfg_blank_en | input | 1 | Enable zeroing during sync and clamp |
| hsync | input | 1 | Horizontal sync pulse, active high |
| clamp | input | 1 | Clamp pulse, active high |
| oe_n | input | 1 | 1 puts all outputs in high impedance |
| a_red | output | 8 | Port A red |
| a_grn | output | 8 | Port A green |
| a_blu | output | 8 | Port A blue |
| a_oor | output | 3 | Port A out-of-range flags |
| b_red | output | 8 | Port B red |
| b_grn | output | 8 | Port B green |
| b_blu | output | 8 | Port B blue |
| b_oor | output | 3 | Port B out-of-range flags |
| half_clk | output | 1 | Half-rate marker of paired data |

## Verification
Port data is due one rising edge after capture. The exception is the odd pixel in synchronous dual-port mode, which is due after two. `half_clk` follows one edge after an even capture. Blanking and output disable act in the same cycle the control is applied. The bench drives each input at a falling edge and updates its reference model right after the next rising edge. It compares the ports at the following falling edge, so register latencies and same-cycle effects are both checked in the cycle they are due. Random pixels, mode changes, and sync, clamp and disable pulses are mixed with directed sequences that place each parity and each mode at known cycles.

// File: rtl/rgb_demux_pkg.sv
// Shared definitions for the pixel port demultiplexer.
// Assumes three colour channels per pixel; widths are set by module parameters.
package rgb_demux_pkg;
    localparam int NCH = 3;

    typedef enum logic [0:0] {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    // Number of bits in one packed pixel for a given sample width.
    function automatic int pix_width(input int dw);
        return NCH * (dw + 1);
    endfunction
endpackage

// File: rtl/rgb_phase_gen.sv
// Pixel parity tracker and half-rate marker.
// Assumes: phase names the parity of the pixel captured at the coming edge;
// it is held at odd during sync so the first pixel after sync is odd.
module rgb_phase_gen
    import rgb_demux_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hsync,
    input  logic   two_port,
    output phase_e phase,
    output logic   half_clk
);

    // Parity toggles every pixel, restarts at odd while sync is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_ODD;
        else if (hsync)
            phase <= PH_ODD;
        else
            phase <= (phase == PH_ODD) ? PH_EVEN : PH_ODD;
    end

    // Marker goes high after each even capture in dual-port mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_clk <= 1'b0;
        else
            half_clk <= two_port && (phase == PH_EVEN);
    end

    p_phase_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync |=> phase != $past(phase));
    p_phase_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> phase == PH_ODD);
    p_half_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        half_clk |-> ($past(two_port) && $past(phase) == PH_EVEN));

endmodule

// File: rtl/rgb_port_steer.sv
// Pixel capture and port steering registers.
// Assumes: configuration inputs are static; a pair register keeps the odd
// pixel for synchronous dual-port timing. Port B is not loaded in single-port mode.
module rgb_port_steer
    import rgb_demux_pkg::*;
#(
    parameter int PW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix_in,
    input  phase_e        phase,
    input  logic          two_port,
    input  logic          odd_on_a,
    input  logic          stagger,
    output logic [PW-1:0] port_a,
    output logic [PW-1:0] port_b
);
    localparam int NPORT = 2;

    logic [PW-1:0] pair_hold;
    logic          is_odd;
    logic          ld_odd_port;
    logic          ld_even_port;
    logic [PW-1:0] odd_data;
    logic [PW-1:0] port_q [NPORT];

    // Decode which port loads and with what data at this edge.
    always_comb begin
        is_odd       = (phase == PH_ODD);
        ld_odd_port  = two_port && (stagger ? is_odd : !is_odd);
        ld_even_port = two_port && !is_odd;
        odd_data     = stagger ? pix_in : pair_hold;
    end

    // Keep each odd pixel until its even partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pair_hold <= '0;
        else if (is_odd)
            pair_hold <= pix_in;
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        logic carries_odd;
        logic ld;
        logic [PW-1:0] nxt;

        // Select the load condition and source for this port.
        always_comb begin
            carries_odd = (gp == 0) ? odd_on_a : !odd_on_a;
            if (gp == 0 && !two_port) begin
                ld  = 1'b1;
                nxt = pix_in;
            end else if (carries_odd) begin
                ld  = ld_odd_port;
                nxt = odd_data;
            end else begin
                ld  = ld_even_port;
                nxt = pix_in;
            end
        end

        // Port output register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_q[gp] <= '0;
            else if (ld)
                port_q[gp] <= nxt;
        end
    end

    assign port_a = port_q[0];
    assign port_b = port_q[1];

    p_single_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !two_port |=> port_a == $past(pix_in));
    p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (two_port && !stagger && is_odd) |=> ($stable(port_a) && $stable(port_b)));
    p_stag_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (two_port && stagger) |=> ($stable(port_a) || $stable(port_b)));
    p_even_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (two_port && !is_odd && odd_on_a) |=> port_b == $past(pix_in));

endmodule

// File: rtl/rgb_out_stage.sv
// Output conditioning: blanking and single-port zeroing of port B.
// Assumes: blanking is applied after the port registers, combinationally.
module rgb_out_stage #(
    parameter int PW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] port_a,
    input  logic [PW-1:0] port_b,
    input  logic          two_port,
    input  logic          blank_en,
    input  logic          hsync,
    input  logic          clamp,
    output logic [PW-1:0] out_a,
    output logic [PW-1:0] out_b
);
    localparam int NPORT = 2;

    logic          blank;
    logic [PW-1:0] src  [NPORT];
    logic [PW-1:0] dst  [NPORT];

    // Blank condition from the pulses seen in this cycle.
    always_comb blank = blank_en && (hsync || clamp);

    assign src[0] = port_a;
    assign src[1] = port_b;

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_cond
        // Zero the port when blanked or unused.
        always_comb begin
            if (blank || (gp == 1 && !two_port))
                dst[gp] = '0;
            else
                dst[gp] = src[gp];
        end
    end

    assign out_a = dst[0];
    assign out_b = dst[1];

    p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_en && (hsync || clamp)) |-> (out_a == '0 && out_b == '0));
    p_b_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !two_port |-> out_b == '0);

endmodule

// File: rtl/rgb_port_demux.sv
// Top: three-channel pixel demultiplexer onto one or two output ports.
// Assumes: cfg_* inputs are static register bits; oe_n high floats all outputs.
module rgb_port_demux
    import rgb_demux_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   in_red,
    input  logic [DW-1:0]   in_grn,
    input  logic [DW-1:0]   in_blu,
    input  logic [NCH-1:0]  in_oor,
    input  logic            cfg_two_port,
    input  logic            cfg_odd_on_a,
    input  logic            cfg_stagger,
    input  logic            cfg_blank_en,
    input  logic            hsync,
    input  logic            clamp,
    input  logic            oe_n,
    output logic [DW-1:0]   a_red,
    output logic [DW-1:0]   a_grn,
    output logic [DW-1:0]   a_blu,
    output logic [NCH-1:0]  a_oor,
    output logic [DW-1:0]   b_red,
    output logic [DW-1:0]   b_grn,
    output logic [DW-1:0]   b_blu,
    output logic [NCH-1:0]  b_oor,
    output logic            half_clk
);
    localparam int PW = pix_width(DW);

    logic [PW-1:0] pix_in;
    logic [PW-1:0] reg_a, reg_b;
    logic [PW-1:0] out_a, out_b;
    phase_e        phase;
    logic          half_q;

    assign pix_in = {in_oor, in_blu, in_grn, in_red};

    rgb_phase_gen i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .two_port (cfg_two_port),
        .phase    (phase),
        .half_clk (half_q)
    );

    rgb_port_steer #(.PW(PW)) i_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_in   (pix_in),
        .phase    (phase),
        .two_port (cfg_two_port),
        .odd_on_a (cfg_odd_on_a),
        .stagger  (cfg_stagger),
        .port_a   (reg_a),
        .port_b   (reg_b)
    );

    rgb_out_stage #(.PW(PW)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_a   (reg_a),
        .port_b   (reg_b),
        .two_port (cfg_two_port),
        .blank_en (cfg_blank_en),
        .hsync    (hsync),
        .clamp    (clamp),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    // Output drivers, floated when disabled.
    assign a_red    = oe_n ? 'z : out_a[DW-1:0];
    assign a_grn    = oe_n ? 'z : out_a[2*DW-1:DW];
    assign a_blu    = oe_n ? 'z : out_a[3*DW-1:2*DW];
    assign a_oor    = oe_n ? 'z : out_a[PW-1:3*DW];
    assign b_red    = oe_n ? 'z : out_b[DW-1:0];
    assign b_grn    = oe_n ? 'z : out_b[2*DW-1:DW];
    assign b_blu    = oe_n ? 'z : out_b[3*DW-1:2*DW];
    assign b_oor    = oe_n ? 'z : out_b[PW-1:3*DW];
    assign half_clk = oe_n ? 1'bz : half_q;

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (reg_a == '0 && reg_b == '0 && !half_q && phase == PH_ODD));
    p_single_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_two_port |=> !half_q);

endmodule

// File: tb/test_rgb_port_demux.sv
module test_rgb_port_demux;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] in_red = '0, in_grn = '0, in_blu = '0;
    logic [2:0] in_oor = '0;
    logic cfg_two_port = 0, cfg_odd_on_a = 1, cfg_stagger = 0, cfg_blank_en = 0;
    logic hsync = 0, clamp = 0, oe_n = 0;
    logic [7:0] a_red, a_grn, a_blu, b_red, b_grn, b_blu;
    logic [2:0] a_oor, b_oor;
    logic half_clk;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [26:0] m_a, m_b, m_hold;
    logic m_ph, m_half;

    rgb_port_demux i_rgb_port_demux (
        .clk(clk), .rst_n(rst_n),
        .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu), .in_oor(in_oor),
        .cfg_two_port(cfg_two_port), .cfg_odd_on_a(cfg_odd_on_a),
        .cfg_stagger(cfg_stagger), .cfg_blank_en(cfg_blank_en),
        .hsync(hsync), .clamp(clamp), .oe_n(oe_n),
        .a_red(a_red), .a_grn(a_grn), .a_blu(a_blu), .a_oor(a_oor),
        .b_red(b_red), .b_grn(b_grn), .b_blu(b_blu), .b_oor(b_oor),
        .half_clk(half_clk)
    );

    always #4 clk = ~clk;

    function automatic logic [26:0] port_a_val();
        return {a_oor, a_blu, a_grn, a_red};
    endfunction
    function automatic logic [26:0] port_b_val();
        return {b_oor, b_blu, b_grn, b_red};
    endfunction

    task automatic chk(input string tag, input logic [26:0] act, input logic [26:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Floating outputs read as z in four-state tools and 0 in two-state tools.
    task automatic chk_float(input string tag, input logic [26:0] act);
        n_chk++;
        if (!($isunknown(act) || act == '0)) begin
            n_err++;
            $display("FAIL %s actual=%h expected=zzz", tag, act);
        end
    endtask

    task automatic model_reset();
        m_a = '0; m_b = '0; m_hold = '0; m_ph = 1'b1; m_half = 1'b0;
    endtask

    // Reference register update for one edge.
    task automatic model_edge(input logic [26:0] x);
        logic odd;
        odd = m_ph;
        if (!cfg_two_port) begin
            m_a = x;
        end else if (cfg_stagger) begin
            if (odd == cfg_odd_on_a) m_a = x; else m_b = x;
        end else if (!odd) begin
            if (cfg_odd_on_a) begin m_a = m_hold; m_b = x; end
            else begin m_b = m_hold; m_a = x; end
        end
        if (odd) m_hold = x;
        m_half = cfg_two_port && !odd;
        m_ph = hsync ? 1'b1 : ~m_ph;
    endtask

    task automatic compare();
        logic blank;
        string ta, tb;
        blank = cfg_blank_en && (hsync || clamp);
        if (oe_n) begin
            chk_float("R9 port A", port_a_val());
            chk_float("R9 port B", port_b_val());
            chk_float("R9 half_clk", {26'd0, half_clk});
            return;
        end
        if (blank) begin ta = "R8 port A"; tb = "R8 port B"; end
        else if (!cfg_two_port) begin ta = "R2 port A"; tb = "R3 port B"; end
        else if (cfg_stagger) begin ta = "R7 port A"; tb = "R7 port B"; end
        else begin ta = "R6 port A"; tb = "R5 port B"; end
        chk(ta, port_a_val(), blank ? '0 : m_a);
        chk(tb, port_b_val(), (blank || !cfg_two_port) ? '0 : m_b);
        chk("R10 half_clk", {26'd0, half_clk}, {26'd0, m_half});
    endtask

    task automatic step(input logic [26:0] px);
        {in_oor, in_blu, in_grn, in_red} = px;
        @(posedge clk);
        model_edge(px);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 port A reset", port_a_val(), '0);
        chk("R11 port B reset", port_b_val(), '0);
        chk("R11 half_clk reset", {26'd0, half_clk}, '0);
        rst_n = 1'b1;

        // R1: flags and samples travel together in single-port mode
        step({3'b101, 8'h33, 8'h22, 8'h11});
        chk("R1 bundle A", port_a_val(), {3'b101, 8'h33, 8'h22, 8'h11});
        chk("R3 B idle", port_b_val(), '0);

        // R4/R7: restart phase with sync, then interleaved, odd on A
        cfg_two_port = 1; cfg_stagger = 1; cfg_odd_on_a = 1;
        hsync = 1; step(27'h0);
        hsync = 0;
        step(27'h1AA_0001);
        chk("R4 first odd on A", port_a_val(), 27'h1AA_0001);
        step(27'h0BB_0002);
        chk("R4 even on B", port_b_val(), 27'h0BB_0002);
        chk("R7 A stays", port_a_val(), 27'h1AA_0001);

        // R6: synchronous pair, odd on B
        cfg_stagger = 0; cfg_odd_on_a = 0;
        hsync = 1; step(27'h0);
        hsync = 0;
        step(27'h0C0_0003);
        step(27'h0D0_0004);
        chk("R6 odd on B after two", port_b_val(), 27'h0C0_0003);
        chk("R5 even on A", port_a_val(), 27'h0D0_0004);
        chk("R10 marker after even", {26'd0, half_clk}, 27'd1);

        // R8: blanking is immediate
        cfg_blank_en = 1; clamp = 1;
        step(27'h7FF_FFFF);
        chk("R8 A blank", port_a_val(), '0);
        clamp = 0; cfg_blank_en = 0;

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            if (i % 250 == 0) begin
                cfg_two_port = $urandom_range(0, 1);
                cfg_odd_on_a = $urandom_range(0, 1);
                cfg_stagger  = $urandom_range(0, 1);
                cfg_blank_en = $urandom_range(0, 1);
            end
            hsync = ($urandom_range(0, 39) == 0);
            clamp = ($urandom_range(0, 29) == 0);
            oe_n  = ($urandom_range(0, 49) == 0);
            step(27'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule